// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block sends a stereo pair of 24-bit two's-complement samples, most significant bit first, on a single serial data line. It supports four framings, chosen by a static two-bit code: right-justified, left-justified, I2S, and a DSP-style framing where a short frame pulse is followed by both channels back to back. The sample pair comes in on a parallel port with a valid/ready handshake. A one-entry holding slot buffers the pair until the next frame begins. If no new pair is waiting when a frame starts, the previous pair is sent again.

The block can run as a clock master or as a clock slave. As master, it divides the system clock by 4 (single and dual rate) or by 2 (quad rate) to make the bit clock, and it drives a word clock with 64 bit-clock slots per frame. As slave, it synchronises an external bit clock and word clock into the system clock domain and follows them. It measures the length of each half-frame so that right-justified data can be placed against the end of the half. In both roles, the data line and the word clock change only after a bit-clock falling edge, so a receiver can sample them on the rising edge.

Top module: `aud_ser_tx`

## Requirements
- R1: Format code 2'b00 selects right-justified framing. The LSB of each channel sits in the last slot of its half-frame and the 23 bits before it fill the slots just ahead of it. The left half has word clock high.
- R2: Format code 2'b01 selects left-justified framing. The MSB sits in slot 0, the first rising bit-clock edge after the word-clock transition, and the remaining bits follow in slots 1 to 23. The left half has word clock high.
- R3: Format code 2'b10 selects I2S framing. The MSB sits in slot 1, one bit clock after the transition, and the LSB sits in slot 24. The left half has word clock low.
- R4: Format code 2'b11 selects DSP framing. The left MSB sits in slot 1 after the frame pulse, left data fills slots 1 to 24 and right data fills slots 25 to 48. As master, the word clock is high for slot 0 only.
- R5: As master, the bit-clock period is 4 system clocks when quad_rate is 0 and 2 when it is 1. A frame has 64 slots, and in non-DSP framings the word clock changes every 32 slots.
- R6: The serial data and the master word clock change only right after a bit-clock falling edge.
- R7: Every slot that carries no sample bit drives 0.
- R8: A new pair is loaded at each frame start (the transition into the left half, or the DSP frame pulse). If nothing is waiting, the previous pair is repeated, and a waiting pair is held unchanged until it is loaded.
- R9: in_ready is high exactly when the holding slot is empty. A pair offered while the slot is empty, in the same cycle a frame starts, goes straight into that frame and leaves the slot empty.
- R10: As slave, the block follows the external bit and word clocks for any half-frame length from 24 to 254 slots. In right-justified framing it uses the measured half-frame length.
- R11: As slave in DSP framing, a frame begins at the rising edge of the frame pulse, whatever the pulse width, provided the pulse is shorter than the frame.
- R12: While reset is asserted and after release in slave mode, bclk_out, lrclk_out and sdata_out are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | 1: generate bit and word clocks; 0: follow external clocks |
| quad_rate | input | 1 | Master divider select: 1 divides by 2, 0 divides by 4 |
| fmt | input | 2 | Framing code (static while running) |
| in_left | input | 24 | Left-channel sample |
| in_right | input | 24 | Right-channel sample |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot empty, pair will be taken |
| bclk_in | input | 1 | External bit clock (slave) |
| lrclk_in | input | 1 | External word clock or frame pulse (slave) |
| bclk_out | output | 1 | Generated bit clock (master), 0 in slave |
| lrclk_out | output | 1 | Generated word clock (master), 0 in slave |
| sdata_out | output | 1 | Serial data |

## Verification
The delicate coincidence is a frame start landing in the same system-clock cycle as a handshake accept while the holding slot is empty. The pair must then bypass the slot and be sent in the frame that is just beginning. The bench finds a word-clock transition as master, counts exactly one frame of system clocks, and raises in_valid only for the cycle ending on the next frame-start edge. It then requires in_ready to stay high and the captured frame to carry the new pair from slot 0 onward. A second case offers a pair mid-frame. That pair must wait in the slot with in_ready low, and it must appear only in the following frame.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int WORD_W = 24;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int POS_W  = 8;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef struct packed {
    logic             act;
    logic             rgt;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // word-clock level that marks the left half
  function automatic logic left_lvl(fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  // map a slot position to the word bit it carries (idx WORD_W-1 = MSB)
  function automatic slot_t map_slot(fmt_e f, logic [POS_W-1:0] pos,
                                     logic [POS_W-1:0] half, logic in_right);
    slot_t s;
    int p;
    int h;
    int b;
    p = int'(pos);
    h = int'(half);
    b = -1;
    s.rgt = in_right;
    if (pos != POS_MAX) begin
      case (f)
        FMT_LJ:  if (p < WORD_W) b = WORD_W - 1 - p;
        FMT_I2S: if (p >= 1 && p <= WORD_W) b = WORD_W - p;
        FMT_RJ:  if (p < h && p + WORD_W >= h) b = h - 1 - p;
        default: begin
          if (p >= 1 && p <= WORD_W) begin
            b = WORD_W - p;
            s.rgt = 1'b0;
          end else if (p > WORD_W && p <= 2 * WORD_W) begin
            b = 2 * WORD_W - p;
            s.rgt = 1'b1;
          end
        end
      endcase
    end
    s.act = (b >= 0);
    s.idx = s.act ? IDX_W'(b) : '0;
    return s;
  endfunction

endpackage

// File: rtl/aud_tx_clkgen.sv
module aud_tx_clkgen
  import aud_tx_pkg::*;
#(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2,
  parameter int FRAME    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  fmt_e fmt,
  output logic bclk,
  output logic evt,
  output logic lr_now,
  output logic mark,
  output logic go
);
  localparam int CW   = $clog2(DIV_SLOW > DIV_FAST ? DIV_SLOW : DIV_FAST);
  localparam int FW   = $clog2(FRAME);
  localparam int HALF = FRAME / 2;

  logic [CW-1:0] cnt, cnt_top, cnt_mid;
  logic [FW-1:0] fpos, fpos_nx;
  logic          fall_hit, rise_hit, ll, dsp;

  assign cnt_top  = fast ? CW'(DIV_FAST - 1)     : CW'(DIV_SLOW - 1);
  assign cnt_mid  = fast ? CW'(DIV_FAST / 2 - 1) : CW'(DIV_SLOW / 2 - 1);
  assign fall_hit = (cnt >= cnt_top);
  assign rise_hit = (cnt == cnt_mid);
  assign evt      = run & fall_hit;
  assign fpos_nx  = (fpos == FW'(FRAME - 1)) ? '0 : fpos + FW'(1);
  assign ll       = left_lvl(fmt);
  assign dsp      = (fmt == FMT_DSP);

  always_comb begin
    go = (fpos_nx == '0);
    if (dsp) begin
      lr_now = go;
      mark   = go;
    end else begin
      lr_now = (fpos_nx < FW'(HALF)) ? ll : ~ll;
      mark   = go | (fpos_nx == FW'(HALF));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
      fpos <= FW'(FRAME - 1);
    end else begin
      cnt <= fall_hit ? '0 : cnt + CW'(1);
      if (rise_hit) bclk <= 1'b1;
      if (fall_hit) begin
        bclk <= 1'b0;
        fpos <= fpos_nx;
      end
    end
  end

  // R5
  bclk_low_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !bclk);

endmodule

// File: rtl/aud_tx_slvsync.sv
module aud_tx_slvsync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lr_in,
  output logic evt,
  output logic lr_now
);
  logic [SYNC-1:0] b_sr, l_sr;
  logic            b_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sr  <= '0;
      l_sr  <= '0;
      b_old <= 1'b0;
    end else begin
      b_sr  <= {b_sr[SYNC-2:0], bclk_in};
      l_sr  <= {l_sr[SYNC-2:0], lr_in};
      b_old <= b_sr[SYNC-1];
    end
  end

  assign evt    = b_old & ~b_sr[SYNC-1];
  assign lr_now = l_sr[SYNC-1];

  // R10
  slave_fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

endmodule

// File: rtl/aud_tx_slot.sv
module aud_tx_slot
  import aud_tx_pkg::*;
#(
  parameter int HALF_INIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             mark,
  input  logic             dsp,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] half
);
  logic [POS_W-1:0] pos_q, half_q;
  logic             measure;

  assign measure = mark & ~dsp & (pos_q != POS_MAX);
  assign pos     = mark ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + POS_W'(1));
  assign half    = measure ? pos_q + POS_W'(1) : half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= POS_MAX;
      half_q <= POS_W'(HALF_INIT);
    end else if (evt) begin
      pos_q  <= pos;
      half_q <= half;
    end
  end

  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(pos_q) && $stable(half_q));

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DIV_SLOW    = 4,
  parameter int DIV_FAST    = 2,
  parameter int FRAME_SLOTS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              quad_rate,
  input  logic [1:0]        fmt,
  input  logic [WORD_W-1:0] in_left,
  input  logic [WORD_W-1:0] in_right,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              bclk_in,
  input  logic              lrclk_in,
  output logic              bclk_out,
  output logic              lrclk_out,
  output logic              sdata_out
);
  localparam int HALF_INIT = FRAME_SLOTS / 2;

  fmt_e f;
  logic ll, dsp;
  assign f   = fmt_e'(fmt);
  assign ll  = left_lvl(f);
  assign dsp = (f == FMT_DSP);

  // master clock path
  logic m_bclk, m_evt, m_lr, m_mark, m_go;
  aud_tx_clkgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .FRAME(FRAME_SLOTS)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(master_en), .fast(quad_rate), .fmt(f),
    .bclk(m_bclk), .evt(m_evt), .lr_now(m_lr), .mark(m_mark), .go(m_go)
  );

  // slave clock path
  logic s_evt_raw, s_lr, s_evt, s_mark, s_go;
  logic lr_seen;
  aud_tx_slvsync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lr_in(lrclk_in),
    .evt(s_evt_raw), .lr_now(s_lr)
  );
  assign s_evt  = s_evt_raw & ~master_en;
  assign s_mark = dsp ? (s_lr & ~lr_seen) : (s_lr ^ lr_seen);
  assign s_go   = dsp ? (s_lr & ~lr_seen) : ((s_lr == ll) & (lr_seen != ll));

  // shared event stream
  logic evt, lr_now, mark, go;
  assign evt    = master_en ? m_evt  : s_evt;
  assign lr_now = master_en ? m_lr   : s_lr;
  assign mark   = master_en ? m_mark : s_mark;
  assign go     = master_en ? m_go   : s_go;

  logic [POS_W-1:0] pos_cur, half_cur;
  aud_tx_slot #(.HALF_INIT(HALF_INIT)) u_slot (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mark(mark), .dsp(dsp),
    .pos(pos_cur), .half(half_cur)
  );

  // sample holding and current pair
  logic [WORD_W-1:0] hold_l, hold_r, cur_l, cur_r, nxt_l, nxt_r, use_l, use_r;
  logic              hold_full, acc, take;

  assign in_ready = ~hold_full;
  assign acc      = in_valid & ~hold_full;
  assign take     = evt & go;
  assign nxt_l    = hold_full ? hold_l : (in_valid ? in_left  : cur_l);
  assign nxt_r    = hold_full ? hold_r : (in_valid ? in_right : cur_r);
  assign use_l    = take ? nxt_l : cur_l;
  assign use_r    = take ? nxt_r : cur_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l    <= '0;
      hold_r    <= '0;
      hold_full <= 1'b0;
      cur_l     <= '0;
      cur_r     <= '0;
    end else begin
      if (take) begin
        cur_l     <= nxt_l;
        cur_r     <= nxt_r;
        hold_full <= 1'b0;
      end else if (acc) begin
        hold_l    <= in_left;
        hold_r    <= in_right;
        hold_full <= 1'b1;
      end
    end
  end

  // bit selection
  slot_t sl;
  logic  bit_nx;
  assign sl     = map_slot(f, pos_cur, half_cur, lr_now != ll);
  assign bit_nx = sl.act ? (sl.rgt ? use_r[sl.idx] : use_l[sl.idx]) : 1'b0;

  logic sd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_q    <= 1'b0;
      lr_seen <= 1'b0;
    end else if (evt) begin
      sd_q    <= bit_nx;
      lr_seen <= lr_now;
    end
  end

  assign sdata_out = sd_q;
  assign lrclk_out = master_en & lr_seen;
  assign bclk_out  = m_bclk;

  // R6
  data_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(sdata_out));

  // R8
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && !take |=> hold_full && $stable(hold_l) && $stable(hold_r));

  // R9
  bypass_leaves_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && take |=> in_ready);

endmodule

// File: tb/aud_ser_tx_test.sv
module aud_ser_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, quad_rate = 1'b0;
  logic [1:0] fmt = 2'b01;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_valid = 1'b0;
  logic in_ready, bclk_out, lrclk_out, sdata_out;
  logic bclk_in, lrclk_in;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  aud_ser_tx uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .quad_rate(quad_rate), .fmt(fmt),
    .in_left(in_left), .in_right(in_right), .in_valid(in_valid), .in_ready(in_ready),
    .bclk_in(bclk_in), .lrclk_in(lrclk_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
    .sdata_out(sdata_out)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [127:0] a, input logic [127:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  // codes: 0 right-justified, 1 left-justified, 2 I2S, 3 DSP
  function automatic logic llev(input int f);
    return (f == 2) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [127:0] mask_of(input int h);
    return (128'(1) << (2 * h)) - 128'(1);
  endfunction

  function automatic logic [127:0] exp_bits(input int f, input int h,
                                            input logic [23:0] l, input logic [23:0] r);
    logic [127:0] e;
    int ms_l, ms_r;
    e = '0;
    case (f)
      0: begin ms_l = h - 24; ms_r = 2 * h - 24; end
      1: begin ms_l = 0;      ms_r = h;          end
      2: begin ms_l = 1;      ms_r = h + 1;      end
      default: begin ms_l = 1; ms_r = 25;        end
    endcase
    for (int b = 23; b >= 0; b--) begin
      e[ms_l + 23 - b] = l[b];
      e[ms_r + 23 - b] = r[b];
    end
    return e;
  endfunction

  function automatic logic [127:0] exp_lr(input int f, input int h);
    logic [127:0] e;
    e = '0;
    for (int s = 0; s < 2 * h; s++) begin
      if (f == 3) e[s] = (s == 0);
      else        e[s] = (s < h) ? llev(f) : ~llev(f);
    end
    return e;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_left = l;
    in_right = r;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_frame_start(input int f);
    logic prev, hit;
    prev = lrclk_out;
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      if (f == 3) hit = lrclk_out && !prev;
      else        hit = (lrclk_out == llev(f)) && (prev != llev(f));
      prev = lrclk_out;
    end
  endtask

  task automatic cap(input bit sync, input int f, output logic [127:0] sd, output logic [127:0] lr);
    sd = '0;
    lr = '0;
    if (sync) wait_frame_start(f);
    for (int k = 0; k < 64; k++) begin
      @(posedge bclk_out);
      #2;
      sd[k] = sdata_out;
      lr[k] = lrclk_out;
    end
  endtask

  task automatic bclk_period(output int n);
    logic prev;
    n = 0;
    prev = bclk_out;
    forever begin
      @(negedge clk);
      if (bclk_out && !prev) break;
      prev = bclk_out;
    end
    prev = bclk_out;
    forever begin
      @(negedge clk);
      n++;
      if (bclk_out && !prev) break;
      prev = bclk_out;
    end
  endtask

  // slave clock generator
  logic s_on = 1'b0;
  int s_fmt = 1, s_half = 32, s_pw = 1, s_frames = 0;
  logic [127:0] s_rec, s_last;
  initial begin
    bclk_in = 1'b0;
    lrclk_in = 1'b0;
    s_rec = '0;
    s_last = '0;
    forever begin
      @(negedge clk);
      if (s_on) begin
        #3;
        for (int k = 0; k < 2 * s_half; k++) begin
          bclk_in = 1'b0;
          if (s_fmt == 3) lrclk_in = (k < s_pw);
          else            lrclk_in = (k < s_half) ? llev(s_fmt) : ~llev(s_fmt);
          #160;
          bclk_in = 1'b1;
          s_rec[k] = sdata_out;
          #160;
        end
        s_last = s_rec;
        s_frames++;
      end
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    master_en = 1'b0;
    fmt = 2'b01;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bclk_out && !lrclk_out && !sdata_out && in_ready, "R12", "outputs in reset",
        {bclk_out, lrclk_out, sdata_out, in_ready}, 128'h1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!bclk_out && !lrclk_out && !sdata_out && in_ready, "R12", "outputs after release",
        {bclk_out, lrclk_out, sdata_out, in_ready}, 128'h1);
  endtask

  task automatic t_master(input int f, input logic q, input logic [23:0] l,
                          input logic [23:0] r, input string tag);
    logic [127:0] sd, lr, e, el, m;
    m = mask_of(32);
    master_en = 1'b1;
    fmt = f[1:0];
    quad_rate = q;
    do_reset();
    push(l, r);
    cap(1, f, sd, lr);
    cap(1, f, sd, lr);
    e = exp_bits(f, 32, l, r);
    el = exp_lr(f, 32);
    chk((sd & m) == e, tag, "master data frame", sd & m, e);
    chk((lr & m) == el, "R5", "master word clock pattern", lr & m, el);
  endtask

  task automatic t_repeat_and_pending();
    logic [127:0] sd, lr, e;
    // R8: no new pair, frame repeats
    cap(1, 1, sd, lr);
    e = exp_bits(1, 32, 24'h3C5A96, 24'hC3A569);
    chk((sd & mask_of(32)) == e, "R8", "repeated pair", sd & mask_of(32), e);
    // R9: mid-frame offer waits in slot
    wait_frame_start(1);
    repeat (40) @(negedge clk);
    push(24'h123456, 24'h89ABCD);
    chk(!in_ready, "R9", "ready low with pair waiting", 128'(in_ready), 128'h0);
    cap(1, 1, sd, lr);
    e = exp_bits(1, 32, 24'h123456, 24'h89ABCD);
    chk((sd & mask_of(32)) == e, "R8", "waiting pair sent next frame", sd & mask_of(32), e);
    chk(in_ready, "R9", "ready high after load", 128'(in_ready), 128'h1);
  endtask

  task automatic t_bypass();
    logic [127:0] sd, lr, e;
    wait_frame_start(1);
    repeat (255) @(negedge clk);
    in_left = 24'hA1B2C3;
    in_right = 24'h4D5E6F;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready, "R9", "bypass leaves slot empty", 128'(in_ready), 128'h1);
    cap(0, 1, sd, lr);
    e = exp_bits(1, 32, 24'hA1B2C3, 24'h4D5E6F);
    chk((sd & mask_of(32)) == e, "R9", "bypassed pair in current frame", sd & mask_of(32), e);
  endtask

  task automatic t_edges();
    logic pb, psd, plr;
    int viol;
    viol = 0;
    pb = bclk_out;
    psd = sdata_out;
    plr = lrclk_out;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ((sdata_out != psd || lrclk_out != plr) && !(pb && !bclk_out)) viol++;
      pb = bclk_out;
      psd = sdata_out;
      plr = lrclk_out;
    end
    chk(viol == 0, "R6", "changes only after bclk fall", 128'(viol), 128'h0);
  endtask

  task automatic t_div(input int expn, input string tag);
    int n;
    bclk_period(n);
    chk(n == expn, tag, "bclk period in clk cycles", 128'(n), 128'(expn));
  endtask

  task automatic t_slave(input int f, input int h, input int pw, input logic [23:0] l,
                         input logic [23:0] r, input string tag);
    logic [127:0] e, m;
    int n0;
    master_en = 1'b0;
    fmt = f[1:0];
    do_reset();
    push(l, r);
    s_fmt = f;
    s_half = h;
    s_pw = pw;
    n0 = s_frames;
    s_on = 1'b1;
    wait (s_frames == n0 + 3);
    s_on = 1'b0;
    m = mask_of(h);
    e = exp_bits(f, h, l, r);
    chk((s_last & m) == e, tag, "slave data frame", s_last & m, e);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #(20 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_master(1, 1'b0, 24'h3C5A96, 24'hC3A569, "R2");
    t_div(4, "R5");
    t_edges();
    t_repeat_and_pending();
    t_bypass();
    t_master(1, 1'b0, 24'hFFFFFF, 24'hFFFFFF, "R7");
    t_master(2, 1'b0, 24'h800001, 24'h7FFFFE, "R3");
    t_master(0, 1'b0, 24'hF0F0F1, 24'h0E0E0F, "R1");
    t_master(3, 1'b0, 24'hDEADBE, 24'h5A5A5B, "R4");
    t_master(1, 1'b1, 24'h13579B, 24'h2468AC, "R5");
    t_div(2, "R5");
    t_slave(1, 48, 1, 24'hCAFE01, 24'h0BEEF7, "R10");
    t_slave(0, 40, 1, 24'h9ABCDE, 24'h765432, "R10");
    t_slave(3, 40, 3, 24'hA5A5A5, 24'h3C3C3C, "R11");
    t_slave(2, 32, 1, 24'hFEDCBA, 24'h012345, "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule